// File: doc/BRIEF.md
# USB Host Port Resume Controller

This block holds a host port's resume request flag and times the resume signalling on its own. Software starts a resume by writing 1 to the flag. While the port is suspended, a remote wake-up also starts one: the line moving from the J state to a K state that stays put for two samples. The port drives K for as long as the drive phase lasts. A short idle phase follows, and then the controller clears the flag itself.

A one-clock completion pulse marks the moment the flag clears, so the frame generator can restart traffic at once. Each hardware-detected wake-up also produces a one-clock port-change pulse that feeds the status logic.

The flag only reads 1 while port power is on. Removing power abandons any sequence in progress.

Top module: `port_resume_ctrl`

## Requirements
- R1: With port power on and the controller idle, a write strobe carrying data 1 sets the resume flag and raises `driveK` at the next clock edge.
- R2: While the port is powered, suspended and idle, a J-to-K line transition sets the resume flag within four clocks and gives a one-clock `portChange` pulse. The line encoding is 2'b01 for J and 2'b10 for K.
- R3: `driveK` stays high for exactly `RESUME_MS` millisecond ticks after the sequence starts. It is never high while the flag reads 0.
- R4: After the drive phase, `driveK` is low while the flag stays 1 for `SETTLE_TICKS` (two) further ticks. The flag then clears by itself.
- R5: A write of 0 has no effect, whether the controller is idle or busy. A write of 1 while a sequence runs does not restart the timing.
- R6: With port power off, the flag reads 0 and `driveK` is low. A sequence interrupted by power loss is dropped and gives no completion pulse.
- R7: `resumeDone` is a one-clock pulse, asserted in the same cycle as the flag clears at the end of a completed sequence.
- R8: The line state passes through a synchroniser. A K that lasts only one clock does not set the flag.
- R9: A J-to-K transition is ignored while the port is not suspended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrStrobe | input | 1 | Register write strobe for the resume flag |
| wrData | input | 1 | Value written to the resume flag |
| portPower | input | 1 | Port power enabled |
| portSuspended | input | 1 | Port is in the suspended state |
| lineState | input | 2 | Raw line state, 01 = J, 10 = K |
| msTick | input | 1 | One-clock pulse per millisecond |
| resumeBit | output | 1 | Resume flag readback |
| driveK | output | 1 | Drive K state on the port |
| portChange | output | 1 | One-clock port-change pulse on a detected wake-up |
| resumeDone | output | 1 | One-clock pulse when the flag clears |

## Verification
The hardest situations to reach from the ports are a write landing while a sequence is already running, and power being removed partway through a resume. The stimulus reaches both by issuing ticks one at a time under bench control. It places a write of 0 and a second write of 1 inside the drive phase, then confirms that the K state still ends on the twentieth tick. It also cuts power after five ticks and confirms that no completion pulse appears afterwards. The wake-up path is exercised with three line patterns: a K held for several clocks, a K lasting a single clock, and a K held while the port is not suspended.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam logic [1:0] LINE_J = 2'b01;
  localparam logic [1:0] LINE_K = 2'b10;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_DRIVE  = 2'b01,
    PH_SETTLE = 2'b10
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntStep;
  } ctl_strobe_t;

  // flags from datapath to control
  typedef struct packed {
    logic jkEdge;
    logic driveEnd;
    logic settleEnd;
  } dp_flag_t;
endpackage

// File: rtl/prc_datapath.sv
module prc_datapath
  import prc_pkg::*;
#(
  parameter int RESUME_MS    = 20,
  parameter int SETTLE_TICKS = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  lineState,
  input  logic        msTick,
  input  ctl_strobe_t ctl,
  output dp_flag_t    flags
);
  localparam int MAX_COUNT = (RESUME_MS > SETTLE_TICKS) ? RESUME_MS : SETTLE_TICKS;
  localparam int CNT_W     = $clog2(MAX_COUNT + 1);
  localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(RESUME_MS - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_TICKS - 1);

  logic [1:0] syncStage [SYNC_STAGES];

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncStage[g] <= LINE_J;
          else       syncStage[g] <= lineState;
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncStage[g] <= LINE_J;
          else       syncStage[g] <= syncStage[g-1];
      end
    end
  endgenerate

  logic [1:0] lineNow;
  logic [1:0] histOne;
  logic [1:0] histTwo;
  assign lineNow = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histOne <= LINE_J;
      histTwo <= LINE_J;
    end else begin
      histOne <= lineNow;
      histTwo <= histOne;
    end
  end

  logic [CNT_W-1:0] tickCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          tickCnt <= '0;
    else if (ctl.cntClr)                tickCnt <= '0;
    else if (ctl.cntStep && msTick)     tickCnt <= tickCnt + 1'b1;
  end

  always_comb begin
    flags.jkEdge    = (lineNow == LINE_K) && (histOne == LINE_K) && (histTwo == LINE_J);
    flags.driveEnd  = msTick && (tickCnt == DRIVE_LAST);
    flags.settleEnd = msTick && (tickCnt == SETTLE_LAST);
  end
endmodule

// File: rtl/prc_ctrl.sv
module prc_ctrl
  import prc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStrobe,
  input  logic        wrData,
  input  logic        portPower,
  input  logic        portSuspended,
  input  dp_flag_t    flags,
  output ctl_strobe_t ctl,
  output logic        flagOut,
  output logic        driveOut,
  output logic        changeOut,
  output logic        doneOut
);
  phase_e phase, phaseNext;
  logic   changeNext, doneNext;

  always_comb begin
    phaseNext   = phase;
    ctl.cntClr  = 1'b0;
    ctl.cntStep = (phase != PH_IDLE);
    changeNext  = 1'b0;
    doneNext    = 1'b0;
    if (!portPower) begin
      phaseNext  = PH_IDLE;
      ctl.cntClr = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          changeNext = flags.jkEdge && portSuspended;
          if ((wrStrobe && wrData) || changeNext) begin
            phaseNext  = PH_DRIVE;
            ctl.cntClr = 1'b1;
          end
        end
        PH_DRIVE: begin
          if (flags.driveEnd) begin
            phaseNext  = PH_SETTLE;
            ctl.cntClr = 1'b1;
          end
        end
        PH_SETTLE: begin
          if (flags.settleEnd) begin
            phaseNext  = PH_IDLE;
            ctl.cntClr = 1'b1;
            doneNext   = 1'b1;
          end
        end
        default: begin
          phaseNext  = PH_IDLE;
          ctl.cntClr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      changeOut <= 1'b0;
      doneOut   <= 1'b0;
    end else begin
      phase     <= phaseNext;
      changeOut <= changeNext;
      doneOut   <= doneNext;
    end
  end

  assign flagOut  = (phase != PH_IDLE) && portPower;
  assign driveOut = (phase == PH_DRIVE) && portPower;
endmodule

// File: rtl/port_resume_ctrl.sv
module port_resume_ctrl
  import prc_pkg::*;
#(
  parameter int RESUME_MS    = 20,
  parameter int SETTLE_TICKS = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStrobe,
  input  logic       wrData,
  input  logic       portPower,
  input  logic       portSuspended,
  input  logic [1:0] lineState,
  input  logic       msTick,
  output logic       resumeBit,
  output logic       driveK,
  output logic       portChange,
  output logic       resumeDone
);
  ctl_strobe_t ctlBus;
  dp_flag_t    flagBus;

  prc_datapath #(
    .RESUME_MS(RESUME_MS), .SETTLE_TICKS(SETTLE_TICKS), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN), .lineState(lineState), .msTick(msTick),
    .ctl(ctlBus), .flags(flagBus)
  );

  prc_ctrl uCtl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .portPower(portPower), .portSuspended(portSuspended), .flags(flagBus),
    .ctl(ctlBus), .flagOut(resumeBit), .driveOut(driveK),
    .changeOut(portChange), .doneOut(resumeDone)
  );
endmodule

// File: rtl/prc_checker.sv
module prc_checker (
  input logic clk,
  input logic rstN,
  input logic wrStrobe,
  input logic wrData,
  input logic portPower,
  input logic resumeBit,
  input logic driveK,
  input logic portChange,
  input logic resumeDone
);
  // R1
  start_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrData && portPower && !resumeBit) |=> (driveK || !portPower));
  // R2
  change_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    portChange |-> (resumeBit || !portPower));
  // R2
  change_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    portChange |=> !portChange);
  // R3
  drive_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveK |-> resumeBit);
  // R4
  self_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(resumeBit) && portPower) |-> resumeDone);
  // R6
  power_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portPower |-> (!resumeBit && !driveK));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeDone |=> !resumeDone);
  // R7
  done_flag_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeDone |-> !resumeBit);
endmodule

bind port_resume_ctrl prc_checker uChk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
  .portPower(portPower), .resumeBit(resumeBit), .driveK(driveK),
  .portChange(portChange), .resumeDone(resumeDone)
);

// File: tb/sim_port_resume_ctrl.sv
`timescale 1ns/1ps
module sim_port_resume_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStrobe = 1'b0, wrData = 1'b0, portPower = 1'b1, portSuspended = 1'b0;
  logic [1:0] lineState = 2'b01;
  logic msTick = 1'b0;
  logic resumeBit, driveK, portChange, resumeDone;

  int compared = 0;
  int mismatched = 0;
  string expQ[$];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  port_resume_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .portPower(portPower), .portSuspended(portSuspended), .lineState(lineState),
    .msTick(msTick), .resumeBit(resumeBit), .driveK(driveK),
    .portChange(portChange), .resumeDone(resumeDone)
  );

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    msTick = 1'b1; step(1); msTick = 1'b0; step(1);
  endtask

  task automatic swWrite(input logic v);
    wrStrobe = 1'b1; wrData = v; step(1); wrStrobe = 1'b0; wrData = 1'b0;
  endtask

  // monitor: pops expected pulse events and compares
  always @(negedge clk) begin
    if (rstN && (portChange || resumeDone)) begin
      string got;
      got = portChange ? "CHG" : "DONE";
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R7/R2 pulse actual=%s expected=none", got);
      end else begin
        string want;
        want = expQ.pop_front();
        if (want != got) begin
          mismatched++;
          $display("FAIL R7/R2 pulse actual=%s expected=%s", got, want);
        end
      end
    end
  end

  initial begin
    step(3);
    // reset state
    check("R6 reset flag", resumeBit, 1'b0);
    check("R3 reset driveK", driveK, 1'b0);
    rstN = 1'b1;
    step(2);

    // R5: write 0 while idle
    swWrite(1'b0);
    check("R5 write0 idle", resumeBit, 1'b0);

    // R1: software start
    swWrite(1'b1);
    check("R1 flag set", resumeBit, 1'b1);
    check("R1 driveK", driveK, 1'b1);
    for (int i = 0; i < 19; i++) begin
      tick();
      if (i == 9) begin
        swWrite(1'b0);
        check("R5 write0 busy", resumeBit, 1'b1);
        swWrite(1'b1);
      end
    end
    check("R3 driveK before last tick", driveK, 1'b1);
    tick();
    check("R3 driveK after RESUME_MS ticks no restart R5", driveK, 1'b0);
    check("R4 flag during settle", resumeBit, 1'b1);
    tick();
    check("R4 flag after one settle tick", resumeBit, 1'b1);
    expQ.push_back("DONE");
    tick();
    check("R4 flag cleared", resumeBit, 1'b0);
    check("R7 done gone", resumeDone, 1'b0);

    // R2: remote wake-up
    portSuspended = 1'b1;
    lineState = 2'b01; step(4);
    expQ.push_back("CHG");
    lineState = 2'b10; step(6);
    check("R2 wake sets flag", resumeBit, 1'b1);
    check("R2 wake drives K", driveK, 1'b1);
    expQ.push_back("DONE");
    for (int i = 0; i < 22; i++) tick();
    check("R2 wake sequence cleared", resumeBit, 1'b0);
    lineState = 2'b01; step(4);

    // R8: one-clock K glitch
    lineState = 2'b10; step(1); lineState = 2'b01; step(6);
    check("R8 glitch ignored", resumeBit, 1'b0);

    // R9: not suspended
    portSuspended = 1'b0;
    lineState = 2'b10; step(6);
    check("R9 not suspended ignored", resumeBit, 1'b0);
    lineState = 2'b01; step(4);

    // R6: power off mid sequence
    swWrite(1'b1);
    for (int i = 0; i < 5; i++) tick();
    portPower = 1'b0; step(1);
    check("R6 flag reads 0", resumeBit, 1'b0);
    check("R6 driveK low", driveK, 1'b0);
    swWrite(1'b1);
    portPower = 1'b1; step(2);
    check("R6 sequence dropped", resumeBit, 1'b0);
    for (int i = 0; i < 24; i++) tick();
    check("R6 no late done", resumeDone, 1'b0);

    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R7 pending events actual=%0d expected=0", expQ.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule